// File: doc/BRIEF.md
# Serial Register Port with Staged Update

This block is a serial control port slave that lets a host reach a byte-wide register space over a chip-select, a serial clock and one or two data lines. Each access begins with a 16-bit instruction. The instruction carries the direction, a byte count and a start address, and it is followed by data bytes. The address falls by one for every byte that follows. All port pins are sampled in the system clock domain through synchronizers, so the serial clock must run well below the system clock.

Writes to the configuration registers reach a buffer bank. The active bank that the rest of the chip uses changes only when the host sets the update bit. The chip reads the active bank, and may write it, through a parallel side port. Readback comes either from the shared data line (three-wire mode, the default) or from a separate output line (four-wire mode). Both directions are controlled by output enables, so the pad logic can build the tri-state lines.

Top module: `spiport`

## Requirements
- R1: The instruction is 16 bits, most significant bit first. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 are the byte count code. Bits 12:0 are the start address.
- R2: Count codes 0, 1 and 2 transfer exactly 1, 2 and 3 bytes. Extra write bytes are ignored and extra read bytes are not driven. Code 3 keeps transferring bytes until chip-select rises.
- R3: The first data byte uses the start address. Each later byte uses the address one lower than the byte before it.
- R4: Input bits are taken on rising serial-clock edges. Read bits are launched on falling edges, most significant bit first. The first read bit is launched on the falling edge that follows the last instruction bit.
- R5: After reset the port is in three-wire mode. Read data appears on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low.
- R6: Register 0 holds the mode. Its bits 7 and 0 mirror each other: writing either bit as 1 sets both. When they are set, read data appears on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low. Both enables are low while chip-select is high and outside the read data bytes.
- R7: Addresses 2 to 14 are staged registers. A serial write to one of them changes only its buffer copy.
- R8: Writing a byte with bit 0 set to address 15 copies every buffer entry into the active bank. Writing a byte with bit 0 clear to address 15 copies nothing. Reading address 15 returns 0.
- R9: Bit 0 of register 1 selects the source for serial reads of staged registers: 0 returns the buffer copy and 1 returns the active copy.
- R10: Raising chip-select at any point ends the access. A partly shifted byte is dropped, and the next access starts with a new instruction.
- R11: `hw_rdata` shows the active value at `hw_addr`. A cycle with `hw_we` high writes `hw_wdata` into that active entry.
- R12: After reset all registers read 0. Addresses 16 and above read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output side |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Separate read data line |
| sdo_oe | output | 1 | Drive enable for the separate line |
| hw_we | input | 1 | Side port write strobe into the active bank |
| hw_addr | input | 4 | Side port register index |
| hw_wdata | input | 8 | Side port write data |
| hw_rdata | output | 8 | Active value at hw_addr |

## Verification
The bench looks at the point where buffer and active copies differ. A read made through the active selector before the update must return the old value, so a design that writes straight through is caught. An update byte with bit 0 clear must change nothing, which catches a decoder that triggers on the address alone. Multi-byte and streaming transfers check the descending address and the byte limit: an ascending counter puts data in the wrong registers, and an ignored count code writes the extra byte into the register below. Aborts in the middle of a byte and in the middle of the instruction check that a stale bit counter does not corrupt the next access. Reads in four-wire mode, and the byte after a count runs out, check which line is driven and when it is released.

// File: rtl/spiport_pkg.sv
`timescale 1ns/1ps
package spiport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // chip-select inactive
        ST_HDR,    // shifting the 16-bit instruction
        ST_WDATA,  // receiving write bytes
        ST_RDATA,  // launching read bytes
        ST_RTAIL,  // holding the final read bit until the next falling edge
        ST_DONE    // byte count used up, waiting for chip-select to rise
    } port_state_e;
endpackage

// File: rtl/spiport_front.sv
`timescale 1ns/1ps
module spiport_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    logic [STAGES-1:0] cs_q, ck_q, d_q;
    logic              ck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= '1;
            ck_q    <= '0;
            d_q     <= '0;
            ck_prev <= 1'b0;
        end else begin
            cs_q    <= {cs_q[STAGES-2:0], cs_n};
            ck_q    <= {ck_q[STAGES-2:0], sclk};
            d_q     <= {d_q[STAGES-2:0], sdi};
            ck_prev <= ck_q[STAGES-1];
        end
    end

    assign cs_act   = ~cs_q[STAGES-1];
    assign sck_rise = ck_q[STAGES-1] & ~ck_prev;
    assign sck_fall = ~ck_q[STAGES-1] & ck_prev;
    assign sdi_s    = d_q[STAGES-1];
endmodule

// File: rtl/spiport_fsm.sv
`timescale 1ns/1ps
module spiport_fsm
    import spiport_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              drive,
    output logic              out_bit
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int CNT_W = $clog2(HDR_W);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

    port_state_e       st, st_nx;
    logic [CNT_W-1:0]  bcnt;
    logic [HDR_W-2:0]  hdr;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        rem;
    logic              stream;
    logic [DATA_W-2:0] dsh;
    logic              obit;

    logic [HDR_W-1:0]  hdr_full;
    logic [DATA_W-1:0] wbyte;
    logic              hdr_end, wbyte_end, rbyte_end, last_byte;

    assign hdr_full  = {hdr, sdi};
    assign wbyte     = {dsh, sdi};
    assign hdr_end   = (st == ST_HDR)   && sck_rise && (bcnt == HDR_LAST);
    assign wbyte_end = (st == ST_WDATA) && sck_rise && (bcnt == BYTE_LAST);
    assign rbyte_end = (st == ST_RDATA) && sck_fall && (bcnt == BYTE_LAST);
    assign last_byte = !stream && (rem == 2'd0);

    // next state
    always_comb begin
        st_nx = st;
        if (!cs_act) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  st_nx = ST_HDR;
                ST_HDR:   if (hdr_end) st_nx = hdr_full[HDR_W-1] ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (wbyte_end && last_byte) st_nx = ST_DONE;
                ST_RDATA: if (rbyte_end && last_byte) st_nx = ST_RTAIL;
                ST_RTAIL: if (sck_fall) st_nx = ST_DONE;
                ST_DONE:  st_nx = ST_DONE;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // shift and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt   <= '0;
            hdr    <= '0;
            addr   <= '0;
            rem    <= '0;
            stream <= 1'b0;
            dsh    <= '0;
            obit   <= 1'b0;
        end else if (!cs_act || st == ST_IDLE) begin
            bcnt <= '0;
        end else begin
            unique case (st)
                ST_HDR: if (sck_rise) begin
                    hdr <= hdr_full[HDR_W-2:0];
                    if (bcnt == HDR_LAST) begin
                        bcnt   <= '0;
                        addr   <= hdr_full[ADDR_W-1:0];
                        rem    <= hdr_full[ADDR_W+1:ADDR_W];
                        stream <= &hdr_full[ADDR_W+1:ADDR_W];
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_WDATA: if (sck_rise) begin
                    if (bcnt == BYTE_LAST) begin
                        bcnt <= '0;
                        addr <= addr - 1'b1;
                        if (!stream && rem != 2'd0) rem <= rem - 1'b1;
                    end else begin
                        dsh  <= wbyte[DATA_W-2:0];
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_RDATA: if (sck_fall) begin
                    if (bcnt == '0) begin
                        obit <= rd_data[DATA_W-1];
                        dsh  <= rd_data[DATA_W-2:0];
                        bcnt <= CNT_W'(1);
                    end else begin
                        obit <= dsh[DATA_W-2];
                        dsh  <= {dsh[DATA_W-3:0], 1'b0};
                        if (bcnt == BYTE_LAST) begin
                            bcnt <= '0;
                            addr <= addr - 1'b1;
                            if (!stream && rem != 2'd0) rem <= rem - 1'b1;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_stb  = wbyte_end;
        wr_addr = addr;
        wr_data = wbyte;
        rd_addr = addr;
        drive   = (st == ST_RDATA) || (st == ST_RTAIL);
        out_bit = obit;
    end

    assert_release_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !drive);
    assert_descending_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (wr_addr == $past(wr_addr) - 1'b1));
    assert_no_read_in_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR) |-> !drive);
endmodule

// File: rtl/spiport_regs.sv
`timescale 1ns/1ps
module spiport_regs #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     hw_we,
    input  logic [$clog2(DEPTH)-1:0] hw_addr,
    input  logic [DATA_W-1:0]        hw_wdata,
    output logic [DATA_W-1:0]        hw_rdata,
    output logic                     four_wire
);
    localparam int IDX_W        = $clog2(DEPTH);
    localparam int UPD_IDX      = DEPTH - 1;
    localparam int FIRST_STAGED = 2;

    logic [DATA_W-1:0]             mode_q, sel_q;
    logic [DEPTH-1:0][DATA_W-1:0]  buf_q, act_q;
    logic                          hit, upd_fire, mir;
    logic [IDX_W-1:0]              widx, ridx;

    assign widx     = wr_addr[IDX_W-1:0];
    assign ridx     = rd_addr[IDX_W-1:0];
    assign hit      = wr_stb && (wr_addr < ADDR_W'(DEPTH));
    assign upd_fire = hit && (widx == IDX_W'(UPD_IDX)) && wr_data[0];
    assign mir      = wr_data[DATA_W-1] | wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            sel_q  <= '0;
        end else if (hit) begin
            if (widx == IDX_W'(0)) mode_q <= {mir, wr_data[DATA_W-2:1], mir};
            if (widx == IDX_W'(1)) sel_q  <= wr_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i >= FIRST_STAGED && i < UPD_IDX) begin : g_staged
            logic [DATA_W-1:0] b_r, a_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    b_r <= '0;
                    a_r <= '0;
                end else begin
                    if (hit && widx == IDX_W'(i)) b_r <= wr_data;
                    if (hw_we && hw_addr == IDX_W'(i)) a_r <= hw_wdata;
                    else if (upd_fire)                 a_r <= b_r;
                end
            end
            assign buf_q[i] = b_r;
            assign act_q[i] = a_r;
        end else begin : g_plain
            assign buf_q[i] = '0;
            assign act_q[i] = '0;
        end
    end

    always_comb begin
        if (rd_addr >= ADDR_W'(DEPTH))       rd_data = '0;
        else if (ridx == IDX_W'(0))          rd_data = mode_q;
        else if (ridx == IDX_W'(1))          rd_data = sel_q;
        else if (ridx == IDX_W'(UPD_IDX))    rd_data = '0;
        else                                 rd_data = sel_q[0] ? act_q[ridx] : buf_q[ridx];
    end

    assign hw_rdata  = act_q[hw_addr];
    assign four_wire = mode_q[DATA_W-1];

    assert_update_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !hw_we) |=> (act_q == $past(buf_q)));
    assert_active_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_fire && !hw_we) |=> $stable(act_q));
    assert_mode_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[DATA_W-1] == mode_q[0]);
endmodule

// File: rtl/spiport.sv
`timescale 1ns/1ps
module spiport #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdio_in,
    output logic                     sdio_out,
    output logic                     sdio_oe,
    output logic                     sdo_out,
    output logic                     sdo_oe,
    input  logic                     hw_we,
    input  logic [$clog2(DEPTH)-1:0] hw_addr,
    input  logic [DATA_W-1:0]        hw_wdata,
    output logic [DATA_W-1:0]        hw_rdata
);
    logic              cs_act, sck_rise, sck_fall, sdi_s;
    logic              wr_stb, drive, out_bit, four_wire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    spiport_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdio_in),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    spiport_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi(sdi_s), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .drive(drive), .out_bit(out_bit)
    );

    spiport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_we(hw_we), .hw_addr(hw_addr), .hw_wdata(hw_wdata),
        .hw_rdata(hw_rdata), .four_wire(four_wire)
    );

    assign sdio_out = out_bit;
    assign sdo_out  = out_bit;
    assign sdio_oe  = drive & ~four_wire;
    assign sdo_oe   = drive & four_wire;

    assert_one_line_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));
    assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) && cs_n |-> !(sdio_oe || sdo_oe) || $past(drive));
endmodule

// File: tb/spiport_bench.sv
`timescale 1ns/1ps
module spiport_bench;
    localparam int HALF = 80;
    localparam int NV   = 12;
    // row: {read, addr[12:0], wdata[7:0], expected[7:0]}
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 13'd3,  8'h00, 8'h00},  // reset value
        {1'b0, 13'd3,  8'hA5, 8'h00},
        {1'b1, 13'd3,  8'h00, 8'hA5},  // buffer holds write
        {1'b0, 13'd1,  8'h01, 8'h00},  // select active copy
        {1'b1, 13'd3,  8'h00, 8'h00},  // active not yet updated
        {1'b0, 13'd15, 8'h01, 8'h00},  // update
        {1'b1, 13'd3,  8'h00, 8'hA5},  // active after update
        {1'b1, 13'd15, 8'h00, 8'h00},  // update reg reads 0
        {1'b0, 13'd20, 8'h77, 8'h00},  // unmapped write
        {1'b1, 13'd20, 8'h00, 8'h00},  // unmapped read
        {1'b0, 13'd1,  8'h00, 8'h00},  // select buffer again
        {1'b1, 13'd3,  8'h00, 8'hA5}   // buffer copy
    };
    localparam int VREQ [NV] = '{12, 0, 7, 0, 7, 0, 8, 8, 0, 12, 0, 9};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_drv = 1'b0;
    logic       sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic       hw_we = 1'b0;
    logic [3:0] hw_addr = '0;
    logic [7:0] hw_wdata = '0, hw_rdata;

    spiport u_spiport (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_drv),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .hw_we(hw_we), .hw_addr(hw_addr), .hw_wdata(hw_wdata), .hw_rdata(hw_rdata)
    );

    int   n_chk = 0, n_bad = 0, oe_bad = 0;
    bit   four = 1'b0, finished = 1'b0;
    logic [7:0] wq [4];
    logic [7:0] rq [4];

    function automatic string tag(int n);
        case (n)
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(bit v);
        sdio_drv = v;
        #HALF; sclk = 1'b1;
        #HALF; sclk = 1'b0;
    endtask

    // full transfer; nb bytes clocked, whatever the count code says
    task automatic xfer(bit rd, bit [1:0] code, bit [12:0] a, int nb);
        logic [15:0] h;
        int nvalid;
        h = {rd, code, a};
        nvalid = (code == 2'd3) ? nb : int'(code) + 1;
        oe_bad = 0;
        cs_n = 1'b0;
        #HALF;
        for (int i = 15; i >= 0; i--) clk_bit(h[i]);
        for (int b = 0; b < nb; b++) begin
            for (int i = 7; i >= 0; i--) begin
                sdio_drv = rd ? 1'b0 : wq[b][i];
                #HALF;
                if (rd) begin
                    rq[b][i] = four ? sdo_out : sdio_out;
                    if (sdio_oe !== ((b < nvalid) && !four)) oe_bad++;
                    if (sdo_oe  !== ((b < nvalid) &&  four)) oe_bad++;
                end
                sclk = 1'b1; #HALF; sclk = 1'b0;
            end
        end
        #HALF; cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic partial(logic [15:0] h, int hbits, int dbits);
        cs_n = 1'b0;
        #HALF;
        for (int i = 15; i > 15 - hbits; i--) clk_bit(h[i]);
        for (int i = 0; i < dbits; i++) clk_bit(1'b1);
        #HALF; cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic wr1(bit [12:0] a, logic [7:0] d);
        wq[0] = d;
        xfer(1'b0, 2'd0, a, 1);
    endtask

    task automatic rd1(bit [12:0] a);
        xfer(1'b1, 2'd0, a, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R12 reset hw_rdata", hw_rdata, 8'h00);
        chk("R5 reset sdio_oe", sdio_oe, 1'b0);
        chk("R6 reset sdo_oe", sdo_oe, 1'b0);

        // vector table, single-byte transfers (R1 header, R5 three-wire)
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][29]) begin
                rd1(VEC[k][28:16]);
                chk(tag(VREQ[k]), rq[0], VEC[k][7:0]);
                chk("R5 table oe", oe_bad, 0);
            end else begin
                wr1(VEC[k][28:16], VEC[k][15:8]);
            end
        end

        // R11 side port read and write
        hw_addr = 4'd3; #1;
        chk("R11 hw read", hw_rdata, 8'hA5);
        @(negedge clk); hw_we = 1'b1; hw_addr = 4'd4; hw_wdata = 8'h3C;
        @(negedge clk); hw_we = 1'b0;
        wr1(13'd1, 8'h01);
        rd1(13'd4);  chk("R11 active via serial", rq[0], 8'h3C);
        wr1(13'd1, 8'h00);
        rd1(13'd4);  chk("R7 buffer untouched by side port", rq[0], 8'h00);

        // R8 update byte with bit 0 clear; R9 source select
        wr1(13'd3, 8'h5C);
        wr1(13'd15, 8'h02);
        hw_addr = 4'd3; #1;
        chk("R8 no copy on bit0=0", hw_rdata, 8'hA5);
        rd1(13'd3);  chk("R9 buffer source", rq[0], 8'h5C);
        wr1(13'd1, 8'h01);
        rd1(13'd3);  chk("R9 active source", rq[0], 8'hA5);
        wr1(13'd1, 8'h00);

        // R2 R3 three-byte write then read, descending addresses; R4 edges
        wq[0] = 8'h11; wq[1] = 8'h22; wq[2] = 8'h33;
        xfer(1'b0, 2'd2, 13'd8, 3);
        xfer(1'b1, 2'd2, 13'd8, 3);
        chk("R3 byte0 addr8", rq[0], 8'h11);
        chk("R3 byte1 addr7", rq[1], 8'h22);
        chk("R4 byte2 addr6", rq[2], 8'h33);
        chk("R5 multi oe", oe_bad, 0);

        // R2 count code 0 ignores an extra byte
        wq[0] = 8'h5A; wq[1] = 8'h99;
        xfer(1'b0, 2'd0, 13'd5, 2);
        rd1(13'd4);  chk("R2 extra write byte ignored", rq[0], 8'h00);
        xfer(1'b1, 2'd0, 13'd5, 2);
        chk("R2 single read value", rq[0], 8'h5A);
        chk("R6 released after count", oe_bad, 0);

        // R2 streaming code 3
        wq[0] = 8'hC1; wq[1] = 8'hC2; wq[2] = 8'hC3; wq[3] = 8'hC4;
        xfer(1'b0, 2'd3, 13'd12, 4);
        rd1(13'd9);  chk("R2 stream fourth byte", rq[0], 8'hC4);
        xfer(1'b1, 2'd3, 13'd12, 4);
        chk("R2 stream read first", rq[0], 8'hC1);
        chk("R2 stream read last", rq[3], 8'hC4);

        // R10 aborts
        partial({1'b0, 2'd0, 13'd6}, 16, 5);
        rd1(13'd6);  chk("R10 partial byte dropped", rq[0], 8'h33);
        partial({1'b0, 2'd0, 13'd7}, 7, 0);
        rd1(13'd7);  chk("R10 fresh start after header abort", rq[0], 8'h22);

        // R6 four-wire mode
        wr1(13'd0, 8'h80);
        four = 1'b1;
        rd1(13'd0);  chk("R6 mirrored mode bits", rq[0], 8'h81);
        rd1(13'd8);  chk("R6 read on separate line", rq[0], 8'h11);
        chk("R6 four-wire oe", oe_bad, 0);
        wr1(13'd0, 8'h00);
        four = 1'b0;
        rd1(13'd8);  chk("R5 back to shared line", rq[0], 8'h11);
        chk("R5 shared line oe", oe_bad, 0);

        // R8 copy of a multi-byte staged set
        wr1(13'd15, 8'h01);
        hw_addr = 4'd9; #1;
        chk("R8 copy reaches addr9", hw_rdata, 8'hC4);
        hw_addr = 4'd6; #1;
        chk("R8 copy reaches addr6", hw_rdata, 8'h33);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule